// File: doc/BRIEF.md
# Group Magnitude Maximum and Scale-Code Packer

This block sits in front of a block-scaled 4-bit quantiser. It accepts a stream of BF16 activations, one value per cycle, in chunks of 128 elements. Each chunk is split into eight consecutive groups of sixteen. For each group the block finds the largest magnitude and raises it to a fixed minimum. It then emits the result as an FP32 word, which a scale unit elsewhere turns into an 8-bit scale code.

The eight scale codes of a chunk come back through a separate input. The block packs them four to a 32-bit word and emits two words per chunk. After the last element of a chunk the input stays stalled until both packed words have been taken. Scale codes can therefore never mix across chunks.

Control is a three-state machine:
- ST_GATHER accepts elements. It moves to ST_AWAIT when the 128th element is accepted.
- ST_AWAIT waits until all eight codes are held, then moves to ST_SEND.
- ST_SEND presents word 0 and then word 1. It returns to ST_GATHER when the last word is accepted, and clears the code count at that point.

Top module: `group_amax_packer`

## Requirements
- R1: A synchronous active-high reset clears the element counter, the code count and the held codes. After reset, in_ready is 1, amax_valid is 0 and word_valid is 0, and a partly received group is discarded.
- R2: amax_valid is high for exactly one cycle, in the cycle after the 16th element of a group is accepted. Each 128-element chunk yields eight pulses, in group order.
- R3: amax_data is the largest magnitude in the group. Magnitude is the BF16 value with bit 15 cleared, compared as an unsigned integer. The result is widened to FP32 as {magnitude, 16'h0000}, so bit 31 is 0.
- R4: When the widened maximum is below 32'h38D1B717 (1.0e-4), amax_data is 32'h38D1B717 instead. All-zero groups, negative-zero groups and tiny groups therefore all report that value.
- R5: in_ready is 0 from the cycle after the 128th element of a chunk is accepted until the second packed word is accepted. No amax pulse occurs while words are being sent.
- R6: Scale codes are taken in order on scale_valid, as groups 0 to 7 of the current chunk. A code offered while eight codes are already held, or while words are being sent, is ignored and changes no output word.
- R7: Word 0 carries groups 0 to 3 and word 1 carries groups 4 to 7. Group g sits at bits [8*(g mod 4)+7 : 8*(g mod 4)]. Word 0 is presented before word 1.
- R8: Once raised, word_valid stays high and word_data stays unchanged until word_ready is seen high.
- R9: A cycle with in_valid low advances no counter, and its in_data affects no maximum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Element offered |
| in_ready | output | 1 | Element accepted when high together with in_valid |
| in_data | input | 16 | BF16 element |
| amax_valid | output | 1 | One-cycle pulse carrying a group maximum |
| amax_data | output | 32 | Floored group maximum, FP32 |
| scale_valid | input | 1 | Scale code offered |
| scale_code | input | 8 | 8-bit scale code of the next group |
| word_valid | output | 1 | Packed word presented |
| word_ready | input | 1 | Packed word taken when high together with word_valid |
| word_data | output | 32 | Four packed scale codes |

## Verification
The hardest cases to reach from the ports are a surplus scale code and a bubble in the element stream.

A surplus code can only matter after all eight codes of a chunk are held. The bench offers a ninth code, with a value not used elsewhere, straight after the eighth. It keeps that code offered while word_ready is held low, then checks that both words still carry only the eight expected codes.

The bench also puts idle cycles into the element stream at irregular points. During each idle cycle it drives a huge magnitude on in_data, so a miscounted bubble would show up as a wrong group maximum. A reset in the middle of a chunk, followed by a full chunk, shows whether the group alignment restarts cleanly.

// File: rtl/gap_pkg.sv
package gap_pkg;

    typedef enum logic [1:0] {
        ST_GATHER,
        ST_AWAIT,
        ST_SEND
    } ctl_state_t;

    // 1.0e-4 as an FP32 bit pattern
    localparam logic [31:0] AMAX_FLOOR_FP32 = 32'h38D1_B717;

endpackage

// File: rtl/gap_group_max.sv
module gap_group_max #(
    parameter int DATA_W = 16,
    parameter int OUT_W  = 32,
    parameter logic [OUT_W-1:0] FLOOR = gap_pkg::AMAX_FLOOR_FP32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_take,
    input  logic [DATA_W-1:0] sample_data,
    input  logic              group_first,
    input  logic              group_last,
    output logic              amax_valid,
    output logic [OUT_W-1:0]  amax_data
);
    localparam int PAD_W = OUT_W - DATA_W;
    localparam logic [DATA_W-1:0] SIGN_MASK = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] mag;
    logic [DATA_W-1:0] run_max;
    logic [DATA_W-1:0] cur_max;
    logic [OUT_W-1:0]  widened;
    logic [OUT_W-1:0]  floored;

    always_comb begin
        // Clearing the sign leaves an order-preserving integer for finite values
        mag = sample_data ^ (sample_data & SIGN_MASK);
        if (group_first || mag > run_max) begin
            cur_max = mag;
        end else begin
            cur_max = run_max;
        end
        widened = {cur_max, {PAD_W{1'b0}}};
        floored = (widened < FLOOR) ? FLOOR : widened;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_max    <= '0;
            amax_valid <= 1'b0;
            amax_data  <= '0;
        end else begin
            amax_valid <= sample_take && group_last;
            if (sample_take) begin
                run_max <= cur_max;
            end
            if (sample_take && group_last) begin
                amax_data <= floored;
            end
        end
    end

endmodule

// File: rtl/gap_scale_packer.sv
module gap_scale_packer #(
    parameter int GROUPS = 8,
    parameter int CODE_W = 8,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              code_valid,
    input  logic [CODE_W-1:0] code_data,
    input  logic              code_allow,
    input  logic              restart,
    input  logic [WSEL_W-1:0] word_sel,
    output logic              codes_full,
    output logic [WORD_W-1:0] word_data
);
    localparam int CODES_PER_WORD = WORD_W / CODE_W;
    localparam int WORDS  = GROUPS / CODES_PER_WORD;
    localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int IDX_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam int CNT_W  = $clog2(GROUPS + 1);

    logic [CNT_W-1:0]  code_cnt;
    logic [CODE_W-1:0] codes [GROUPS];
    logic [WORD_W-1:0] word_bus [WORDS];
    logic              code_take;

    assign codes_full = (code_cnt == CNT_W'(GROUPS));
    assign code_take  = code_valid && code_allow && !codes_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_cnt <= '0;
            for (int i = 0; i < GROUPS; i++) begin
                codes[i] <= '0;
            end
        end else if (restart) begin
            code_cnt <= '0;
        end else if (code_take) begin
            codes[code_cnt[IDX_W-1:0]] <= code_data;
            code_cnt <= code_cnt + 1'b1;
        end
    end

    // The lowest group of each word occupies its lowest byte
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar k = 0; k < CODES_PER_WORD; k++) begin : g_lane
            assign word_bus[w][k*CODE_W +: CODE_W] = codes[w*CODES_PER_WORD + k];
        end
    end

    assign word_data = word_bus[word_sel];

endmodule

// File: rtl/gap_ctrl.sv
module gap_ctrl #(
    parameter int GROUP_SIZE = 16,
    parameter int GROUPS     = 8,
    parameter int WORDS      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              codes_full,
    input  logic              word_ready,
    output logic              in_ready,
    output logic              sample_take,
    output logic              group_first,
    output logic              group_last,
    output logic              code_allow,
    output logic              word_valid,
    output logic              restart,
    output logic [WSEL_W-1:0] word_sel
);
    import gap_pkg::*;

    localparam int CHUNK  = GROUP_SIZE * GROUPS;
    localparam int EW     = $clog2(CHUNK);
    localparam int GW     = $clog2(GROUP_SIZE);
    localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    ctl_state_t        state, state_nx;
    logic [EW-1:0]     elem_cnt;
    logic              chunk_last;
    logic              send_fire;
    logic              last_word;

    assign group_first = (elem_cnt[GW-1:0] == '0);
    assign group_last  = (elem_cnt[GW-1:0] == GW'(GROUP_SIZE - 1));
    assign chunk_last  = (elem_cnt == EW'(CHUNK - 1));
    assign last_word   = (word_sel == WSEL_W'(WORDS - 1));

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_GATHER;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_GATHER: if (sample_take && chunk_last) state_nx = ST_AWAIT;
            ST_AWAIT:  if (codes_full)                state_nx = ST_SEND;
            ST_SEND:   if (send_fire && last_word)    state_nx = ST_GATHER;
            default:   state_nx = ST_GATHER;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready   = 1'b0;
        code_allow = 1'b0;
        word_valid = 1'b0;
        unique case (state)
            ST_GATHER: begin
                in_ready   = 1'b1;
                code_allow = 1'b1;
            end
            ST_AWAIT: begin
                code_allow = 1'b1;
            end
            ST_SEND: begin
                word_valid = 1'b1;
            end
            default: begin
                in_ready = 1'b0;
            end
        endcase
        sample_take = in_valid && in_ready;
        send_fire   = word_valid && word_ready;
        restart     = send_fire && last_word;
    end

    // Element and word counters
    always_ff @(posedge clk) begin
        if (rst) begin
            elem_cnt <= '0;
            word_sel <= '0;
        end else begin
            if (sample_take) begin
                elem_cnt <= chunk_last ? '0 : elem_cnt + 1'b1;
            end
            if (restart) begin
                word_sel <= '0;
            end else if (send_fire) begin
                word_sel <= word_sel + 1'b1;
            end
        end
    end

endmodule

// File: rtl/group_amax_packer.sv
module group_amax_packer #(
    parameter int GROUP_SIZE = 16,
    parameter int GROUPS     = 8,
    parameter int DATA_W     = 16,
    parameter int AMAX_W     = 32,
    parameter int CODE_W     = 8,
    parameter int WORD_W     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              amax_valid,
    output logic [AMAX_W-1:0] amax_data,
    input  logic              scale_valid,
    input  logic [CODE_W-1:0] scale_code,
    output logic              word_valid,
    input  logic              word_ready,
    output logic [WORD_W-1:0] word_data
);
    localparam int CODES_PER_WORD = WORD_W / CODE_W;
    localparam int WORDS  = GROUPS / CODES_PER_WORD;
    localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic              sample_take;
    logic              group_first;
    logic              group_last;
    logic              code_allow;
    logic              codes_full;
    logic              restart;
    logic [WSEL_W-1:0] word_sel;

    gap_ctrl #(
        .GROUP_SIZE(GROUP_SIZE),
        .GROUPS    (GROUPS),
        .WORDS     (WORDS)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .codes_full (codes_full),
        .word_ready (word_ready),
        .in_ready   (in_ready),
        .sample_take(sample_take),
        .group_first(group_first),
        .group_last (group_last),
        .code_allow (code_allow),
        .word_valid (word_valid),
        .restart    (restart),
        .word_sel   (word_sel)
    );

    gap_group_max #(
        .DATA_W(DATA_W),
        .OUT_W (AMAX_W),
        .FLOOR (gap_pkg::AMAX_FLOOR_FP32)
    ) u_max (
        .clk        (clk),
        .rst        (rst),
        .sample_take(sample_take),
        .sample_data(in_data),
        .group_first(group_first),
        .group_last (group_last),
        .amax_valid (amax_valid),
        .amax_data  (amax_data)
    );

    gap_scale_packer #(
        .GROUPS(GROUPS),
        .CODE_W(CODE_W),
        .WORD_W(WORD_W)
    ) u_pack (
        .clk       (clk),
        .rst       (rst),
        .code_valid(scale_valid),
        .code_data (scale_code),
        .code_allow(code_allow),
        .restart   (restart),
        .word_sel  (word_sel),
        .codes_full(codes_full),
        .word_data (word_data)
    );

endmodule

// File: rtl/gap_checker.sv
module gap_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        amax_valid,
    input logic [31:0] amax_data,
    input logic        word_valid,
    input logic        word_ready,
    input logic [31:0] word_data
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !amax_valid && !word_valid));

    assert_amax_after_take_R2: assert property (@(posedge clk) disable iff (rst)
        amax_valid |-> $past(in_valid && in_ready));

    assert_amax_single_R2: assert property (@(posedge clk) disable iff (rst)
        amax_valid |=> !amax_valid);

    assert_amax_positive_R3: assert property (@(posedge clk) disable iff (rst)
        amax_valid |-> !amax_data[31]);

    assert_amax_floor_R4: assert property (@(posedge clk) disable iff (rst)
        amax_valid |-> (amax_data >= gap_pkg::AMAX_FLOOR_FP32));

    assert_quiet_send_R5: assert property (@(posedge clk) disable iff (rst)
        (word_valid && word_ready) |=> !amax_valid);

    assert_word_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));

endmodule

bind group_amax_packer gap_checker u_gap_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .amax_valid(amax_valid),
    .amax_data (amax_data),
    .word_valid(word_valid),
    .word_ready(word_ready),
    .word_data (word_data)
);

// File: tb/tb_group_amax_packer.sv
module tb_group_amax_packer;

    localparam logic [31:0] FLOOR = 32'h38D1_B717;

    // Each entry: {peak BF16 for one group, expected FP32 amax}
    localparam logic [47:0] VEC [16] = '{
        {16'h3F80, 32'h3F80_0000}, {16'hC0C0, 32'h40C0_0000},
        {16'h0000, FLOOR},         {16'h3800, FLOOR},
        {16'h38D2, 32'h38D2_0000}, {16'h38D1, FLOOR},
        {16'h8000, FLOOR},         {16'h4780, 32'h4780_0000},
        {16'hBF00, 32'h3F00_0000}, {16'h7F7F, 32'h7F7F_0000},
        {16'h0001, FLOOR},         {16'hC2F6, 32'h42F6_0000},
        {16'h3A83, 32'h3A83_0000}, {16'hFF7F, 32'h7F7F_0000},
        {16'h4000, 32'h4000_0000}, {16'h3C00, 32'h3C00_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        amax_valid;
    logic [31:0] amax_data;
    logic        scale_valid = 1'b0;
    logic [7:0]  scale_code = '0;
    logic        word_valid;
    logic        word_ready = 1'b0;
    logic [31:0] word_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int amax_n = 0;
    logic [31:0] amax_got [8];

    always #2 clk = ~clk;

    group_amax_packer dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .amax_valid(amax_valid), .amax_data(amax_data),
        .scale_valid(scale_valid), .scale_code(scale_code),
        .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data)
    );

    always @(negedge clk) begin
        if (!rst && amax_valid) begin
            if (amax_n < 8) amax_got[amax_n] <= amax_data;
            amax_n <= amax_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] elem(input int e, input int p);
        logic [15:0] pk = VEC[e][47:32];
        if (p == (e % 16)) return pk;
        return {p[0], 1'b0, pk[14:1]};
    endfunction

    function automatic logic [7:0] code_of(input int c, input int g);
        return 8'(8'h31 + c * 8'h40 + g * 8'h09);
    endfunction

    task automatic send_chunk(input int c);
        amax_n = 0;
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            if (i % 7 == 3) begin
                in_valid = 1'b0;
                in_data  = 16'h7F00;   // R9: idle-cycle junk
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = elem(c * 8 + i / 16, i % 16);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 16'h7F00;
    endtask

    task automatic run_chunk(input int c);
        send_chunk(c);
        chk("R5 in_ready low after chunk", 32'(in_ready), 32'd0);
        repeat (2) @(negedge clk);
        chk("R2 eight amax pulses", 32'(amax_n), 32'd8);
        for (int g = 0; g < 8; g++) begin
            if (VEC[c * 8 + g][31:0] == FLOOR)
                chk("R4 floored amax", amax_got[g], FLOOR);
            else
                chk("R3 group amax", amax_got[g], VEC[c * 8 + g][31:0]);
        end
        for (int g = 0; g < 8; g++) begin
            scale_valid = 1'b1;
            scale_code  = code_of(c, g);
            @(negedge clk);
        end
        scale_code = 8'hEE;    // R6: surplus code, must be ignored
        repeat (3) @(negedge clk);
        chk("R7 word0 valid", 32'(word_valid), 32'd1);
        chk("R7 word0", word_data,
            {code_of(c, 3), code_of(c, 2), code_of(c, 1), code_of(c, 0)});
        chk("R5 in_ready low while sending", 32'(in_ready), 32'd0);
        repeat (2) @(negedge clk);
        chk("R8 word0 held", word_data,
            {code_of(c, 3), code_of(c, 2), code_of(c, 1), code_of(c, 0)});
        scale_valid = 1'b0;
        word_ready  = 1'b1;
        @(negedge clk);
        chk("R7 word1 valid", 32'(word_valid), 32'd1);
        chk("R6 R7 word1", word_data,
            {code_of(c, 7), code_of(c, 6), code_of(c, 5), code_of(c, 4)});
        @(negedge clk);
        word_ready = 1'b0;
        chk("R5 in_ready back", 32'(in_ready), 32'd1);
        chk("R8 word_valid drops", 32'(word_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset in_ready", 32'(in_ready), 32'd1);
        chk("R1 reset amax_valid", 32'(amax_valid), 32'd0);
        chk("R1 reset word_valid", 32'(word_valid), 32'd0);

        for (int c = 0; c < 2; c++) run_chunk(c);

        // R1: reset part-way through a chunk, then a full chunk must realign
        for (int i = 0; i < 21; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 16'h4700;
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mid-chunk reset in_ready", 32'(in_ready), 32'd1);
        run_chunk(0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule